// File: doc/BRIEF.md
# Program-Counter-Driven Video Fetch Unit

This block sits between an 8-bit CPU bus and a display memory. It lets the CPU's own instruction fetches act as the raster address counter, so no hardware line counter is needed. Software jumps into a programmed dummy-opcode window placed directly in front of its loop code. For every read inside that window, the block hands the CPU a fixed one-byte, one-address-step no-op in place of the memory contents. The program counter therefore walks through the window one address per bus cycle.

In the same bus cycle, the low address bits, together with a bank latch, address the display memory. At the end of the cycle the byte read there is loaded into a pixel shift register. That register sends it out most significant bit first, one bit per dot-clock tick. The block raises sync and porch flags when a fetch falls in programmed offset spans of the window. Because the CPU is fully busy while a line is rastered, display fetches use the one bus phase and need no arbitration.

The bank latch, the window bounds and the sync spans are written at memory-mapped addresses. A write is held in a shadow copy and takes effect only after a bus cycle outside the window, so a line that is being rastered never changes configuration part way through. The block is clocked by the dot clock. The CPU clock arrives as a one-tick enable that marks the end of each bus cycle.

Top module: `pcv_fetch_unit`

## Requirements
- R1: A read whose address lies in the inclusive window [start, end] returns DUMMY_OP (default 8'hEA) on cpu_rdata. Any other read returns sys_rdata unchanged.
- R2: vid_addr is always {bank, cpu_addr[LOW_W-1:0]}, using the active bank value and the current address, with no register delay.
- R3: When cpu_ce marks the end of a window read, vid_rdata is loaded into the shift register. pix then gives its bits from bit 7 down to bit 0, one per dot tick, during the next 8 ticks.
- R4: A bus cycle that is not a window read loads zero, so pix stays 0 for the whole following bus cycle.
- R5: Let off = address - start. For the bus cycle after a window read, hsync is 1 exactly when off is in [hs_beg, hs_end), and porch is 1 exactly when off is in [pc_beg, pc_end). Both are 0 after any cycle that is not a window read.
- R6: The configuration bytes are written at REG_BASE (default 16'hFF00) plus an index. Index 0 is the bank. Indices 1 and 2 are the window start low and high bytes. Indices 3 and 4 are the window end low and high bytes. Indices 5 and 6 are hs_beg and hs_end. Indices 7 and 8 are pc_beg and pc_end. Writes to indices 9 to 15 change nothing.
- R7: A configuration write becomes active at the end of the first bus cycle after the write that is not a window read. Window reads in between still use the old values.
- R8: After reset, bank is 0, the window is empty (start 16'hFFFF, end 16'h0000), all spans are empty, and pix, hsync and porch are 0.
- R9: A write to an address inside the window is not a window read. It loads nothing, so pix, hsync and porch are 0 in the next bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_ce | input | 1 | One-tick pulse ending each CPU bus cycle |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| sys_rdata | input | 8 | Data from normal ROM or RAM |
| cpu_rdata | output | 8 | Data returned to the CPU |
| vid_addr | output | BANK_W+LOW_W | Display memory address |
| vid_rdata | input | 8 | Display memory data |
| pix | output | 1 | Serial pixel stream |
| hsync | output | 1 | Horizontal sync flag |
| porch | output | 1 | Porch flag |

## Verification
The bench builds the block with its defaults: 8 dot ticks per bus cycle, an 8-bit bank and 8 low address bits. It programs a 32-address window with short sync and porch spans. That small window lets it sweep every address from just before the window start to past its end, first under one bank and then again with a narrowed end under another bank. Every offset, both inclusive bounds and every span edge are therefore compared bit by bit against arithmetic expectations. Directed sequences cover the deferred bank change, a write inside the window and an ignored register index.

// File: rtl/pcv_pkg.sv
package pcv_pkg;
  localparam int CPU_AW = 16;
  localparam int BYTE_W = 8;
  localparam int NREG   = 9;

  localparam int IX_BANK   = 0;
  localparam int IX_WS_LO  = 1;
  localparam int IX_WS_HI  = 2;
  localparam int IX_WE_LO  = 3;
  localparam int IX_WE_HI  = 4;
  localparam int IX_HS_BEG = 5;
  localparam int IX_HS_END = 6;
  localparam int IX_PC_BEG = 7;
  localparam int IX_PC_END = 8;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [CPU_AW-1:0] addr_t;

  // half-open span test on a byte offset
  function automatic logic span_hit(byte_t v, byte_t lo, byte_t hi);
    return (v >= lo) && (v < hi);
  endfunction

  // inclusive range test on a bus address
  function automatic logic addr_in(addr_t a, addr_t lo, addr_t hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // reset contents: empty window, empty spans, bank zero
  function automatic byte_t reset_val(int idx);
    return (idx == IX_WS_LO || idx == IX_WS_HI) ? 8'hFF : 8'h00;
  endfunction
endpackage

// File: rtl/pcv_regs.sv
module pcv_regs
  import pcv_pkg::*;
#(
  parameter int BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_ce,
  input  logic              wr_hit,
  input  logic [3:0]        wr_idx,
  input  byte_t             wdata,
  input  logic              commit_ok,
  output logic [BANK_W-1:0] bank_o,
  output addr_t             win_start_o,
  output addr_t             win_end_o,
  output byte_t             hs_beg_o,
  output byte_t             hs_end_o,
  output byte_t             pc_beg_o,
  output byte_t             pc_end_o
);
  byte_t shadow_q [NREG];
  byte_t active_q [NREG];
  logic  wr_valid;

  assign wr_valid = wr_hit && (int'(wr_idx) < NREG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        shadow_q[i] <= reset_val(i);
        active_q[i] <= reset_val(i);
      end
    end else if (cpu_ce) begin
      if (wr_valid) shadow_q[wr_idx] <= wdata;
      if (commit_ok) begin
        for (int i = 0; i < NREG; i++) active_q[i] <= shadow_q[i];
      end
    end
  end

  assign bank_o      = active_q[IX_BANK][BANK_W-1:0];
  assign win_start_o = {active_q[IX_WS_HI], active_q[IX_WS_LO]};
  assign win_end_o   = {active_q[IX_WE_HI], active_q[IX_WE_LO]};
  assign hs_beg_o    = active_q[IX_HS_BEG];
  assign hs_end_o    = active_q[IX_HS_END];
  assign pc_beg_o    = active_q[IX_PC_BEG];
  assign pc_end_o    = active_q[IX_PC_END];

  // R7: configuration seen by the line stays put across a window read
  a_r7_hold_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ce && !commit_ok) |=> ($stable(bank_o) && $stable(win_start_o) &&
                                $stable(win_end_o) && $stable(hs_beg_o) &&
                                $stable(pc_beg_o)));

  // R6: out-of-range indices leave the shadow copy untouched
  a_r6_ignored_index: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ce && wr_hit && (int'(wr_idx) >= NREG)) |=> $stable(shadow_q[IX_BANK]));
endmodule

// File: rtl/pcv_decode.sv
module pcv_decode
  import pcv_pkg::*;
#(
  parameter addr_t REG_BASE = 16'hFF00
) (
  input  addr_t       cpu_addr,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  input  addr_t       win_start,
  input  addr_t       win_end,
  input  byte_t       hs_beg,
  input  byte_t       hs_end,
  input  byte_t       pc_beg,
  input  byte_t       pc_end,
  output logic        fetch,
  output logic        reg_hit,
  output logic [3:0]  reg_idx,
  output logic        hs_hit,
  output logic        pc_hit
);
  addr_t offset;
  logic  off_short;

  assign fetch     = cpu_rd && addr_in(cpu_addr, win_start, win_end);
  assign offset    = cpu_addr - win_start;
  assign off_short = (offset[CPU_AW-1:BYTE_W] == '0);
  assign hs_hit    = fetch && off_short && span_hit(offset[BYTE_W-1:0], hs_beg, hs_end);
  assign pc_hit    = fetch && off_short && span_hit(offset[BYTE_W-1:0], pc_beg, pc_end);
  assign reg_hit   = cpu_wr && (cpu_addr[CPU_AW-1:4] == REG_BASE[CPU_AW-1:4]);
  assign reg_idx   = cpu_addr[3:0];
endmodule

// File: rtl/pcv_shifter.sv
module pcv_shifter
  import pcv_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cpu_ce,
  input  logic  load_en,
  input  byte_t load_data,
  input  logic  hs_in,
  input  logic  pc_in,
  output logic  pix,
  output logic  hsync,
  output logic  porch
);
  byte_t sh_q;
  logic  hs_q, pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      hs_q <= 1'b0;
      pc_q <= 1'b0;
    end else if (cpu_ce) begin
      sh_q <= load_en ? load_data : '0;
      hs_q <= load_en && hs_in;
      pc_q <= load_en && pc_in;
    end else begin
      sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
    end
  end

  assign pix   = sh_q[BYTE_W-1];
  assign hsync = hs_q;
  assign porch = pc_q;

  // R3: a captured fetch lands whole in the shifter
  a_r3_load_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ce && load_en) |=> (sh_q == $past(load_data)));

  // R3: between bus cycle ends the byte moves one place toward the MSB
  a_r3_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ce |=> (sh_q == {$past(sh_q[BYTE_W-2:0]), 1'b0}));

  // R4: a non-fetch cycle leaves the line blank and sync low
  a_r4_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ce && !load_en) |=> (sh_q == '0 && !hsync && !porch));
endmodule

// File: rtl/pcv_fetch_unit.sv
module pcv_fetch_unit
  import pcv_pkg::*;
#(
  parameter int    LOW_W       = 8,
  parameter int    BANK_W      = 8,
  parameter byte_t DUMMY_OP    = 8'hEA,
  parameter addr_t REG_BASE    = 16'hFF00,
  parameter int    DOT_PER_CPU = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_ce,
  input  logic [15:0]             cpu_addr,
  input  logic                    cpu_rd,
  input  logic                    cpu_wr,
  input  logic [7:0]              cpu_wdata,
  input  logic [7:0]              sys_rdata,
  output logic [7:0]              cpu_rdata,
  output logic [BANK_W+LOW_W-1:0] vid_addr,
  input  logic [7:0]              vid_rdata,
  output logic                    pix,
  output logic                    hsync,
  output logic                    porch
);
  localparam int GAP_W = $clog2(DOT_PER_CPU + 1);

  // named internal events
  logic              fetch;
  logic              reg_hit;
  logic [3:0]        reg_idx;
  logic              hs_hit, pc_hit;
  logic [BANK_W-1:0] bank;
  addr_t             win_start, win_end;
  byte_t             hs_beg, hs_end, pc_beg, pc_end;

  pcv_regs #(.BANK_W(BANK_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce),
    .wr_hit(reg_hit), .wr_idx(reg_idx), .wdata(cpu_wdata),
    .commit_ok(!fetch),
    .bank_o(bank), .win_start_o(win_start), .win_end_o(win_end),
    .hs_beg_o(hs_beg), .hs_end_o(hs_end), .pc_beg_o(pc_beg), .pc_end_o(pc_end)
  );

  pcv_decode #(.REG_BASE(REG_BASE)) i_decode (
    .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .win_start(win_start), .win_end(win_end),
    .hs_beg(hs_beg), .hs_end(hs_end), .pc_beg(pc_beg), .pc_end(pc_end),
    .fetch(fetch), .reg_hit(reg_hit), .reg_idx(reg_idx),
    .hs_hit(hs_hit), .pc_hit(pc_hit)
  );

  pcv_shifter i_shift (
    .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce),
    .load_en(fetch), .load_data(vid_rdata),
    .hs_in(hs_hit), .pc_in(pc_hit),
    .pix(pix), .hsync(hsync), .porch(porch)
  );

  assign cpu_rdata = fetch ? DUMMY_OP : sys_rdata;
  assign vid_addr  = {bank, cpu_addr[LOW_W-1:0]};

  // bus-cycle spacing monitor for the dot/CPU ratio
  logic [GAP_W-1:0] gap_q;
  logic             seen_ce_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q     <= '0;
      seen_ce_q <= 1'b0;
    end else if (cpu_ce) begin
      gap_q     <= '0;
      seen_ce_q <= 1'b1;
    end else if (gap_q != GAP_W'(DOT_PER_CPU)) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // R3: exactly one byte time of dot ticks per bus cycle
  a_r3_ce_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ce && seen_ce_q) |-> (gap_q == GAP_W'(DOT_PER_CPU - 1)));

  // R1: window reads see the substitute opcode, others see memory
  a_r1_dummy_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |-> (cpu_rdata == DUMMY_OP));
  a_r1_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch |-> (cpu_rdata == sys_rdata));

  // R9: without a read strobe there is no display fetch
  a_r9_write_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |-> !fetch);

  // R5: sync and porch only arise from window reads
  a_r5_sync_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_hit || pc_hit) |-> fetch);

  // R2: low display address bits follow the program counter
  a_r2_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    vid_addr[LOW_W-1:0] == cpu_addr[LOW_W-1:0]);
endmodule

// File: tb/test_pcv_fetch_unit.sv
module test_pcv_fetch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_ce = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  sys_rdata;
  logic [7:0]  cpu_rdata;
  logic [15:0] vid_addr;
  logic [7:0]  vid_rdata;
  logic        pix, hsync, porch;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] smem(logic [15:0] a);
    return a[7:0] + a[15:8] + 8'h11;
  endfunction
  function automatic logic [7:0] vmem(logic [15:0] a);
    return (a[7:0] * 8'd37) ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  assign sys_rdata = smem(cpu_addr);
  assign vid_rdata = vmem(vid_addr);

  pcv_fetch_unit i_pcv_fetch_unit (
    .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .cpu_addr(cpu_addr),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .sys_rdata(sys_rdata), .cpu_rdata(cpu_rdata), .vid_addr(vid_addr),
    .vid_rdata(vid_rdata), .pix(pix), .hsync(hsync), .porch(porch)
  );

  // independent model of the configuration
  logic [7:0] m_sh [9];
  logic [7:0] m_act [9];
  logic [7:0] exp_pix = '0;
  logic       exp_hs = 1'b0, exp_pc = 1'b0;
  string      exp_tag = "R8";

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one bus cycle: entered and left just after a falling edge
  task automatic bus(logic [15:0] a, logic rd, logic wr, logic [7:0] wd, string vtag);
    logic [7:0]  got;
    logic [15:0] ws, we, off, va;
    logic        f, hs, pc;
    got[7] = pix;
    chk(hsync == exp_hs, (exp_tag == "R3") ? "R5" : exp_tag, "hsync", hsync, exp_hs);
    chk(porch == exp_pc, (exp_tag == "R3") ? "R5" : exp_tag, "porch", porch, exp_pc);
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = wd;
    for (int i = 6; i >= 0; i--) begin
      @(negedge clk);
      got[i] = pix;
    end
    chk(got == exp_pix, exp_tag, "pixel byte", got, exp_pix);
    ws  = {m_act[2], m_act[1]};
    we  = {m_act[4], m_act[3]};
    f   = rd && (a >= ws) && (a <= we);
    off = a - ws;
    hs  = f && (off < 16'd256) && (off[7:0] >= m_act[5]) && (off[7:0] < m_act[6]);
    pc  = f && (off < 16'd256) && (off[7:0] >= m_act[7]) && (off[7:0] < m_act[8]);
    va  = {m_act[0], a[7:0]};
    chk(vid_addr == va, vtag, "vid_addr", vid_addr, va);
    if (rd) chk(cpu_rdata == (f ? 8'hEA : smem(a)), "R1", "cpu_rdata",
                cpu_rdata, f ? 8'hEA : smem(a));
    cpu_ce = 1'b1;
    @(negedge clk);
    cpu_ce = 1'b0;
    exp_pix = f ? vmem(va) : 8'h00;
    exp_hs  = hs;
    exp_pc  = pc;
    exp_tag = f ? "R3" : ((wr && a >= ws && a <= we) ? "R9" : "R4");
    if (!f) for (int k = 0; k < 9; k++) m_act[k] = m_sh[k];
    if (wr && a[15:4] == 12'hFF0 && a[3:0] < 4'd9) m_sh[a[3:0]] = wd;
  endtask

  task automatic wreg(int idx, logic [7:0] v);
    bus(16'hFF00 + 16'(idx), 1'b0, 1'b1, v, "R2");
  endtask

  initial begin
    for (int k = 0; k < 9; k++) begin
      m_sh[k]  = (k == 1 || k == 2) ? 8'hFF : 8'h00;
      m_act[k] = m_sh[k];
    end
    repeat (3) @(negedge clk);
    chk(pix == 1'b0 && hsync == 1'b0 && porch == 1'b0, "R8", "reset outputs",
        {pix, hsync, porch}, 0);
    rst_n = 1'b1;
    // R8: empty window after reset, bank 0
    bus(16'h2045, 1'b1, 1'b0, 8'h00, "R8");
    bus(16'hFFFF, 1'b1, 1'b0, 8'h00, "R8");
    // R6: program window 0x2040..0x205F, sync [2,5), porch [5,9), bank 3
    wreg(1, 8'h40); wreg(2, 8'h20); wreg(3, 8'h5F); wreg(4, 8'h20);
    wreg(5, 8'h02); wreg(6, 8'h05); wreg(7, 8'h05); wreg(8, 8'h09);
    wreg(0, 8'h03);
    bus(16'h1000, 1'b1, 1'b0, 8'h00, "R6");
    bus(16'h1001, 1'b1, 1'b0, 8'h00, "R6");
    // sweep across both window edges
    for (int a = 16'h2038; a <= 16'h2067; a++) bus(16'(a), 1'b1, 1'b0, 8'h00, "R2");
    // R7: bank write is deferred while the line runs
    wreg(0, 8'h05);
    bus(16'h2050, 1'b1, 1'b0, 8'h00, "R7");
    bus(16'h2051, 1'b1, 1'b0, 8'h00, "R7");
    bus(16'h3000, 1'b1, 1'b0, 8'h00, "R7");
    bus(16'h2050, 1'b1, 1'b0, 8'h00, "R7");
    // R9: write inside the window
    bus(16'h2043, 1'b0, 1'b1, 8'hAA, "R9");
    bus(16'h2044, 1'b1, 1'b0, 8'h00, "R9");
    // R6: index 12 is ignored, bank stays 5
    wreg(12, 8'h77);
    bus(16'h1000, 1'b1, 1'b0, 8'h00, "R6");
    bus(16'h2050, 1'b1, 1'b0, 8'h00, "R6");
    // narrowed window, second sweep under bank 5
    wreg(3, 8'h47);
    bus(16'h1000, 1'b1, 1'b0, 8'h00, "R6");
    for (int a = 16'h203E; a <= 16'h2049; a++) bus(16'(a), 1'b1, 1'b0, 8'h00, "R2");
    bus(16'h1000, 1'b1, 1'b0, 8'h00, "R4");
    bus(16'h1001, 1'b1, 1'b0, 8'h00, "R4");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule